// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a serial slave for a two-wire bus at standard or fast rates. It watches already-sampled clock and data lines. It recognises START and STOP conditions and decodes a seven-bit device address. The lowest bit of that address is taken from a strap pin, so two such slaves can share one bus. It acknowledges bytes by asserting a pull-down enable for the data pad. The pad, the filtering and any clock stretching sit outside the block.

Behind the bus engine sits a small register set reached through a command pointer. Three byte-wide registers can be written and read: a divider select for a derived clock, an output-control byte and a signed frequency trim. A two-byte temperature value comes from an input port and can only be read. A write transfer carries the device address, a command byte and a data byte. A read returns the register the pointer names. The pointer stays where it is, with one exception: reading the temperature high byte moves it to the low byte. Both temperature bytes are taken from a single sample.

Top module: `twoWireRegSlave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal 1000_10 followed by the `addrSel` level. Bit 0 of that byte selects the direction: 0 is write and 1 is read. Any other address gets no acknowledge, and the transfer that follows changes nothing.
- R2: A write transfer is address, command, data. Each byte is acknowledged with SDA low during the ninth clock. Bytes are sent MSB first. The data byte is stored in the register the command names: 5Dh is `freqSel`, 60h is `ctrlBits` and 66h is `tuneOffset`.
- R3: The control register keeps only its bits [3:0]. Bits [7:4] always read as 0 and drive 0 on `ctrlBits`.
- R4: A read transfer returns the register last named by a command, MSB first. The pointer does not advance after a single-byte register, so reading again returns the same byte.
- R5: Command 64h starts a temperature read. The first byte is `tempIn[15:8]` and the next byte is `tempIn[7:0]`. Both bytes come from the `tempIn` value present when the high byte is loaded. The pointer then rests on 65h.
- R6: After the master answers a read byte with NACK, the slave keeps SDA released until the next START or STOP.
- R7: A START at any point begins a new address phase, and a STOP at any point returns the slave to idle. A write cut short by either condition before its data byte is complete leaves every register unchanged.
- R8: A data byte written to 64h, 65h or any unassigned command is acknowledged but changes no register. A read at an unassigned command returns 00h.
- R9: After reset all three registers are 00h and SDA is released.
- R10: The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level |
| addrSel | input | 1 | Strap that sets address bit 0 |
| tempIn | input | 16 | Current temperature word, high byte in [15:8] |
| sdaPullDown | output | 1 | 1 drives the data pad low |
| freqSel | output | 8 | Divider select register |
| ctrlBits | output | 8 | Output-control register, upper nibble zero |
| tuneOffset | output | 8 | Signed frequency trim register |

## Verification
Two events can fall on the same system clock: a new temperature sample arriving on `tempIn`, and the SCL falling edge that loads the high byte for transmission and latches the low byte. The bench forces them together. It changes `tempIn` in the same statement that drops SCL after the address acknowledge, then changes `tempIn` again before the first data bit. Both bytes read back must equal the value that arrived at the capture edge, and neither byte may come from the earlier value or the later one.

// File: rtl/twsPkg.sv
package twsPkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_FREQ    = 8'h5D;
  localparam logic [BYTE_W-1:0] CMD_CTRL    = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_TEMP_HI = 8'h64;
  localparam logic [BYTE_W-1:0] CMD_TEMP_LO = 8'h65;
  localparam logic [BYTE_W-1:0] CMD_TUNE    = 8'h66;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_SKIP
  } busState_e;

  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} byteKind_e;

  typedef struct packed {
    logic cmdLoad;
    logic wrData;
    logic rdTake;
  } regStrobe_t;
endpackage

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter logic [5:0]  ADDR_HI = 6'b100010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] rdByte,
  output logic [BYTE_W-1:0] rxByte,
  output regStrobe_t        strb,
  output logic              sdaPullDown
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sclQ, sdaQ;
  busState_e state;
  byteKind_e kind;
  logic [CNT_W-1:0] bitCnt;
  logic byteDone, rwBit;
  logic [BYTE_W-1:0] rxShift, txShift;

  logic sclRise, sclFall, startSeen, stopSeen, addrMatch;

  assign sclRise   = sclIn && !sclQ;
  assign sclFall   = !sclIn && sclQ;
  assign startSeen = sclIn && sclQ && sdaQ && !sdaIn;
  assign stopSeen  = sclIn && sclQ && !sdaQ && sdaIn;
  assign addrMatch = (rxShift[BYTE_W-1:1] == {ADDR_HI, addrSel});
  assign rxByte    = rxShift;
  assign sdaPullDown = (state == ST_RXACK) ||
                       ((state == ST_TX) && !txShift[BYTE_W-1]);

  always_comb begin
    strb = '0;
    if (sclFall && state == ST_RX && byteDone) begin
      strb.cmdLoad = (kind == K_CMD);
      strb.wrData  = (kind == K_DATA);
    end
    if (sclFall && ((state == ST_RXACK && kind == K_ADDR && rwBit) ||
                    state == ST_TXACK))
      strb.rdTake = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      rwBit    <= 1'b0;
      rxShift  <= '0;
      txShift  <= '1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startSeen) begin
        state    <= ST_RX;
        kind     <= K_ADDR;
        bitCnt   <= '0;
        byteDone <= 1'b0;
      end else if (stopSeen) begin
        state    <= ST_IDLE;
        bitCnt   <= '0;
        byteDone <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
              bitCnt  <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              bitCnt   <= '0;
              if (kind == K_ADDR) begin
                if (addrMatch) begin
                  rwBit <= rxShift[0];
                  state <= ST_RXACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state <= ST_RXACK;
              end
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              if (kind == K_ADDR && rwBit) begin
                state   <= ST_TX;
                txShift <= rdByte;
              end else begin
                state <= ST_RX;
                kind  <= (kind == K_ADDR) ? K_CMD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) byteDone <= 1'b1;
            end else if (sclFall) begin
              if (byteDone) begin
                byteDone <= 1'b0;
                bitCnt   <= '0;
                state    <= ST_TXACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b1};
              end
            end
          end
          ST_TXACK: begin
            if (sclRise && sdaIn) begin
              state <= ST_SKIP;
            end else if (sclFall) begin
              state   <= ST_TX;
              txShift <= rdByte;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: pull-down only moves while SCL is low
  p_sda_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullDown));

  // R7: a STOP always lands in idle with SDA released
  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE && !sdaPullDown));

  // R7: a START always opens an address phase
  p_start_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_RX && kind == K_ADDR && bitCnt == '0));

  // R6: a NACK from the master releases SDA
  p_nack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TXACK && sclRise && sdaIn && !startSeen && !stopSeen)
      |=> (!sdaPullDown && state == ST_SKIP));
endmodule

// File: rtl/twsRegs.sv
module twsRegs
  import twsPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CTRL_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic [2*BYTE_W-1:0] tempIn,
  output logic [BYTE_W-1:0]   rdByte,
  output logic [BYTE_W-1:0]   freqSel,
  output logic [BYTE_W-1:0]   ctrlBits,
  output logic [BYTE_W-1:0]   tuneOffset
);
  localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'((1 << CTRL_BITS) - 1);

  logic [BYTE_W-1:0] ptr, tempLoSnap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      tempLoSnap <= '0;
      freqSel    <= '0;
      ctrlBits   <= '0;
      tuneOffset <= '0;
    end else begin
      if (strb.cmdLoad) ptr <= rxByte;
      if (strb.wrData) begin
        case (ptr)
          CMD_FREQ: freqSel    <= rxByte;
          CMD_CTRL: ctrlBits   <= rxByte & CTRL_MASK;
          CMD_TUNE: tuneOffset <= rxByte;
          default: ;
        endcase
      end
      if (strb.rdTake && ptr == CMD_TEMP_HI) begin
        tempLoSnap <= tempIn[BYTE_W-1:0];
        ptr        <= CMD_TEMP_LO;
      end
    end
  end

  always_comb begin
    case (ptr)
      CMD_FREQ:    rdByte = freqSel;
      CMD_CTRL:    rdByte = ctrlBits;
      CMD_TUNE:    rdByte = tuneOffset;
      CMD_TEMP_HI: rdByte = tempIn[2*BYTE_W-1:BYTE_W];
      CMD_TEMP_LO: rdByte = tempLoSnap;
      default:     rdByte = '0;
    endcase
  end

  // R2: registers move only on a data-write strobe
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> ($stable(freqSel) && $stable(ctrlBits) && $stable(tuneOffset)));

  // R5: loading the high temperature byte steps the pointer to the low byte
  p_temp_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdTake && !strb.cmdLoad && ptr == CMD_TEMP_HI) |=> (ptr == CMD_TEMP_LO));

  // R5: the low-byte snapshot changes only at a capture
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdTake |=> $stable(tempLoSnap));

  // R4: a read load never moves a single-byte pointer
  p_no_incr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdTake && !strb.cmdLoad && ptr != CMD_TEMP_HI) |=> $stable(ptr));
endmodule

// File: rtl/twoWireRegSlave.sv
module twoWireRegSlave
  import twsPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          addrSel,
  input  logic [15:0]   tempIn,
  output logic          sdaPullDown,
  output logic [7:0]    freqSel,
  output logic [7:0]    ctrlBits,
  output logic [7:0]    tuneOffset
);
  regStrobe_t strb;
  logic [BYTE_W-1:0] rxByte, rdByte;

  twsCtrl #(.BYTE_W(BYTE_W), .ADDR_HI(6'b100010)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdByte(rdByte), .rxByte(rxByte), .strb(strb), .sdaPullDown(sdaPullDown)
  );

  twsRegs #(.BYTE_W(BYTE_W), .CTRL_BITS(4)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .tempIn(tempIn),
    .rdByte(rdByte), .freqSel(freqSel), .ctrlBits(ctrlBits), .tuneOffset(tuneOffset)
  );
endmodule

// File: tb/twoWireRegSlave_tb.sv
`timescale 1ns/1ps
module twoWireRegSlave_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b0;
  logic [15:0] tempIn = 16'h0000;
  logic sdaPullDown, sdaBus;
  logic [7:0] freqSel, ctrlBits, tuneOffset;
  int nChecks = 0, nFail = 0, r10Viol = 0;
  logic [7:0] mFreq = 0, mCtrl = 0, mTune = 0;
  logic prevScl = 1'b1, prevPd = 1'b0;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullDown;

  twoWireRegSlave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrSel(addrSel),
    .tempIn(tempIn), .sdaPullDown(sdaPullDown), .freqSel(freqSel),
    .ctrlBits(ctrlBits), .tuneOffset(tuneOffset)
  );

  // R10 monitor: pull-down must hold while SCL stays high
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaPullDown != prevPd)) r10Viol++;
    prevScl <= sclM;
    prevPd  <= sdaPullDown;
  end

  function automatic logic [7:0] expectReg(input logic [7:0] cmd);
    case (cmd)
      8'h5D: return mFreq;
      8'h60: return mCtrl;
      8'h66: return mTune;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepW();
    repeat (3) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; stepW(); sclM = 1'b1; stepW(); sdaM = 1'b0; stepW(); sclM = 1'b0; stepW();
  endtask

  task automatic stopC();
    sdaM = 1'b0; stepW(); sclM = 1'b1; stepW(); sdaM = 1'b1; stepW();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd,
                          input logic doSwap = 1'b0, input logic [15:0] tSwap = 16'h0);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; stepW(); sclM = 1'b1; stepW(); sclM = 1'b0; stepW();
    end
    sdaM = 1'b1; stepW(); sclM = 1'b1; stepW();
    ackd = !sdaBus;
    sclM = 1'b0;
    if (doSwap) tempIn = tSwap;
    stepW();
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      stepW(); sclM = 1'b1; stepW(); b[i] = sdaBus; sclM = 1'b0;
    end
    sdaM = !ackIt; stepW(); sclM = 1'b1; stepW(); sclM = 1'b0; stepW(); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devW(); return {6'b100010, addrSel, 1'b0}; endfunction
  function automatic logic [7:0] devR(); return {6'b100010, addrSel, 1'b1}; endfunction

  task automatic writeReg(input logic [7:0] cmd, input logic [7:0] d, output logic allAck);
    logic a0, a1, a2;
    startC(); sendByte(devW(), a0); sendByte(cmd, a1); sendByte(d, a2); stopC();
    allAck = a0 & a1 & a2;
  endtask

  task automatic readReg(input logic [7:0] cmd, output logic [7:0] v);
    logic a;
    startC(); sendByte(devW(), a); sendByte(cmd, a);
    startC(); sendByte(devR(), a); recvByte(1'b0, v); stopC();
  endtask

  task automatic readAgain(output logic [7:0] v);
    logic a;
    startC(); sendByte(devR(), a); recvByte(1'b0, v); stopC();
  endtask

  initial begin
    logic ok, a;
    logic [7:0] v, hi, lo, cmd, d;
    void'($urandom(32'd4721));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9 freqSel", freqSel, 8'h00);
    chk("R9 ctrlBits", ctrlBits, 8'h00);
    chk("R9 tuneOffset", tuneOffset, 8'h00);
    chk("R9 sda released", sdaPullDown, 1'b0);

    // R2 write path
    writeReg(8'h5D, 8'hA5, ok); mFreq = 8'hA5;
    chk("R2 write acks", ok, 1'b1);
    chk("R2 freqSel", freqSel, 8'hA5);

    // R3 control masking
    writeReg(8'h60, 8'hFF, ok); mCtrl = 8'h0F;
    chk("R3 ctrlBits", ctrlBits, 8'h0F);
    readReg(8'h60, v);
    chk("R3 ctrl readback", v, 8'h0F);

    // R1 address mismatch, then strap change
    addrSel = 1'b1;
    startC(); sendByte({6'b100010, 1'b0, 1'b0}, a); sendByte(8'h66, ok); sendByte(8'h55, ok); stopC();
    chk("R1 wrong addr nack", a, 1'b0);
    chk("R1 no effect", tuneOffset, 8'h00);
    writeReg(8'h66, 8'h9C, ok); mTune = 8'h9C;
    chk("R1 strap addr ack", ok, 1'b1);
    chk("R1 tuneOffset", tuneOffset, 8'h9C);

    // R4 pointer stays on single-byte register
    readReg(8'h66, v);
    chk("R4 first read", v, 8'h9C);
    readAgain(v);
    chk("R4 repeat read", v, 8'h9C);

    // R5 temperature capture coinciding with a new sample
    tempIn = 16'h1111;
    startC(); sendByte(devW(), a); sendByte(8'h64, a);
    startC(); sendByte(devR(), a, 1'b1, 16'h4B40);
    tempIn = 16'hD8C0;
    recvByte(1'b1, hi); recvByte(1'b0, lo); stopC();
    chk("R5 temp hi", hi, 8'h4B);
    chk("R5 temp lo", lo, 8'h40);
    readAgain(v);
    chk("R5 pointer on lo", v, 8'h40);

    // R6 one-byte read, NACK, extra clocks see released SDA
    tempIn = 16'h2A80;
    startC(); sendByte(devW(), a); sendByte(8'h64, a);
    startC(); sendByte(devR(), a); recvByte(1'b0, hi);
    chk("R5 one-byte hi", hi, 8'h2A);
    sclM = 1'b1; stepW();
    chk("R6 released after nack", sdaBus, 1'b1);
    sclM = 1'b0; stepW();
    chk("R6 still released", sdaPullDown, 1'b0);
    stopC();

    // R7 repeated START and STOP cut writes short
    startC(); sendByte(devW(), a); sendByte(8'h5D, a);
    startC(); sendByte(devW(), a); sendByte(8'h66, a); sendByte(8'h33, a); stopC(); mTune = 8'h33;
    chk("R7 aborted write", freqSel, 8'hA5);
    chk("R7 restarted write", tuneOffset, 8'h33);
    startC(); sendByte(devW(), a); sendByte(8'h5D, a);
    for (int i = 0; i < 4; i++) begin
      sdaM = 1'b0; stepW(); sclM = 1'b1; stepW(); sclM = 1'b0; stepW();
    end
    stopC();
    chk("R7 stop mid byte", freqSel, 8'hA5);
    writeReg(8'h5D, 8'h3C, ok); mFreq = 8'h3C;
    chk("R7 recovers after stop", freqSel, 8'h3C);

    // R8 writes to read-only and unknown commands
    writeReg(8'h64, 8'h77, ok);
    chk("R8 ack on temp write", ok, 1'b1);
    writeReg(8'h12, 8'h77, ok);
    chk("R8 regs untouched", {freqSel, ctrlBits, tuneOffset}, {mFreq, mCtrl, mTune});
    readReg(8'h12, v);
    chk("R8 unknown reads zero", v, 8'h00);

    // R2 R3 R4 random register traffic
    for (int n = 0; n < 24; n++) begin
      case ($urandom % 3)
        0: cmd = 8'h5D;
        1: cmd = 8'h60;
        default: cmd = 8'h66;
      endcase
      d = 8'($urandom);
      addrSel = 1'($urandom);
      writeReg(cmd, d, ok);
      if (cmd == 8'h5D) mFreq = d;
      else if (cmd == 8'h60) mCtrl = d & 8'h0F;
      else mTune = d;
      readReg(cmd, v);
      chk("R4 random readback", v, expectReg(cmd));
      chk("R2 random outputs", {freqSel, ctrlBits, tuneOffset}, {mFreq, mCtrl, mTune});
    end

    chk("R10 pull-down moved with SCL high", r10Viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule